// File: doc/BRIEF.md
# Microsequenced Call/Return Control Core

This block is the control core of a small byte-oriented processor. It holds a 16-bit program counter, an 8-bit instruction register and a 16-bit holding register. It talks to memory over one byte-wide synchronous port. Each instruction is a one-byte opcode, optionally followed by operand bytes that arrive low byte first. A T-state counter steps through the microsteps of the current instruction. A purely combinational microcode table turns the pair (T-state, opcode) into a control word, which drives the datapath registers and the memory port in that cycle.

The supported instructions are no-operation, absolute jump, subroutine call and subroutine return. The call does not use a stack. The return address is written to two fixed cells at the very top of memory: the low byte goes to FFFEh and the high byte to FFFFh. The return reloads the program counter from those same two cells. Every opcode outside the four defined ones runs as a no-operation. The memory returns read data one cycle after it sees the address.

Top module: `callseq_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the core presents an opcode fetch at address 0000h (`fetch_o` high) with `mem_we` low.
- R2: Every instruction starts with exactly one opcode fetch cycle. In that cycle `fetch_o` is high and `mem_addr` equals the program counter. Opcode values: 00h no-operation, C3h jump, CDh call, C9h return.
- R3: A jump takes its target from the two bytes that follow the opcode, low byte first. The next fetch happens at that target.
- R4: Instruction length, counted from one fetch to the next: no-operation 4 cycles, jump 7, return 6, call 18 (parameter `CALL_STATES`). No instruction takes fewer than 4 cycles.
- R5: A call writes the address of the byte after its two operand bytes as the return address. The low byte is written to FFFEh, and the high byte is written to FFFFh in the very next cycle.
- R6: After a call, the next opcode fetch happens at the call's little-endian target address.
- R7: A return loads the program-counter low byte from FFFEh and the high byte from FFFFh, and fetches its next opcode from the restored address.
- R8: Any opcode other than the four defined ones takes 4 cycles, performs no write, and is followed by a fetch from the next sequential address.
- R9: `mem_we` is asserted only during the two save cycles of a call, and only to FFFEh or FFFFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Memory address for the current cycle |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe, taken at the next rising edge |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| fetch_o | output | 1 | High during an opcode fetch cycle |

## Verification
The core's outputs are combinational decodes of its registered state, so the address, write strobe and fetch marker are all valid in the same cycle as the microstep that produces them. The latency that matters is the gap between fetches. The bench samples at falling edges and counts falling edges from one `fetch_o` to the next. That count must equal the cycle budget in R4, which already includes the one-cycle read delay of every operand and save-cell access. Within each gap, the bench records every cycle in which `mem_we` is high. A call must show exactly two writes in adjacent cycles, to FFFEh and then FFFFh. Every other instruction must show none.

// File: rtl/callseq_pkg.sv
package callseq_pkg;
   localparam logic [7:0] OP_NOP  = 8'h00;
   localparam logic [7:0] OP_JMP  = 8'hC3;
   localparam logic [7:0] OP_CALL = 8'hCD;
   localparam logic [7:0] OP_RET  = 8'hC9;

   typedef enum logic {AS_PC = 1'b0, AS_SAVE = 1'b1} asel_e;

   typedef struct packed {
      asel_e addr_sel;    // program counter or fixed save cell
      logic  lane;        // byte lane for save cell, holding reg, pc byte
      logic  pc_inc;
      logic  ir_ld;
      logic  tmp_ld;
      logic  pc_byte_ld;
      logic  pc_from_tmp;
      logic  mem_wr;
      logic  last;
   } uword_t;
endpackage

// File: rtl/callseq_tstep.sv
module callseq_tstep #(
   parameter int TW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          last,
   output logic [TW-1:0] tstate
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tstate <= '0;
      else if (last) tstate <= '0;
      else           tstate <= tstate + TW'(1);
   end
endmodule

// File: rtl/callseq_ucode.sv
module callseq_ucode
   import callseq_pkg::*;
#(
   parameter int TW          = 5,
   parameter int CALL_STATES = 18
) (
   input  logic [TW-1:0] tstate,
   input  logic [7:0]    opcode,
   output uword_t        uw
);
   int unsigned ts;
   assign ts = int'(tstate);

   always_comb begin
      uw = '0;
      if (ts == 0) begin
         uw.pc_inc = 1'b1;                 // opcode read at PC
      end else if (ts == 1) begin
         uw.ir_ld = 1'b1;                  // opcode byte arrives
      end else begin
         case (opcode)
            OP_JMP, OP_CALL: begin
               case (ts)
                  2, 4: uw.pc_inc = 1'b1;  // operand address out
                  3:    uw.tmp_ld = 1'b1;
                  5: begin
                     uw.tmp_ld = 1'b1;
                     uw.lane   = 1'b1;
                  end
                  default: ;
               endcase
               if (opcode == OP_JMP && ts == 6) begin
                  uw.pc_from_tmp = 1'b1;
                  uw.last        = 1'b1;
               end
               if (opcode == OP_CALL) begin
                  if (ts == 6 || ts == 7) begin
                     uw.addr_sel = AS_SAVE;
                     uw.mem_wr   = 1'b1;
                     uw.lane     = (ts == 7);
                  end
                  if (ts == CALL_STATES - 1) begin
                     uw.pc_from_tmp = 1'b1;
                     uw.last        = 1'b1;
                  end
               end
            end
            OP_RET: begin
               case (ts)
                  2: uw.addr_sel = AS_SAVE;
                  3: uw.pc_byte_ld = 1'b1;
                  4: begin
                     uw.addr_sel = AS_SAVE;
                     uw.lane     = 1'b1;
                  end
                  5: begin
                     uw.pc_byte_ld = 1'b1;
                     uw.lane       = 1'b1;
                     uw.last       = 1'b1;
                  end
                  default: ;
               endcase
            end
            default: begin                 // no-operation and undefined codes
               if (ts == 3) uw.last = 1'b1;
            end
         endcase
      end
   end
endmodule

// File: rtl/callseq_dpath.sv
module callseq_dpath
   import callseq_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  uword_t        uw,
   input  logic [DW-1:0] rdata,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] wdata,
   output logic          we,
   output logic [7:0]    opcode
);
   localparam int NB = AW / DW;
   localparam logic [AW-1:0] SAVE_BASE = ~AW'(NB - 1);

   logic [NB-1:0][DW-1:0] pc_q;
   logic [NB-1:0][DW-1:0] tmp_q;
   logic [DW-1:0]         ir_q;

   for (genvar b = 0; b < NB; b++) begin : g_tmp_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tmp_q[b] <= '0;
         else if (uw.tmp_ld && int'(uw.lane) == b)
            tmp_q[b] <= rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
         ir_q <= '0;
      end else begin
         if (uw.ir_ld) ir_q <= rdata;
         if (uw.pc_from_tmp)     pc_q <= tmp_q;
         else if (uw.pc_byte_ld) pc_q[uw.lane] <= rdata;
         else if (uw.pc_inc)     pc_q <= pc_q + AW'(1);
      end
   end

   assign addr   = (uw.addr_sel == AS_SAVE) ? (SAVE_BASE | AW'(uw.lane)) : pc_q;
   assign wdata  = pc_q[uw.lane];
   assign we     = uw.mem_wr;
   assign opcode = ir_q[7:0];
endmodule

// File: rtl/callseq_core.sv
module callseq_core
   import callseq_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 8,
   parameter int TW          = 5,
   parameter int CALL_STATES = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_we,
   input  logic [DW-1:0] mem_rdata,
   output logic          fetch_o
);
   if (AW != 2 * DW) begin : g_bad_width
      $error("callseq_core: address width must be twice the data width");
   end
   if (DW < 8) begin : g_bad_dw
      $error("callseq_core: data width must hold an opcode");
   end
   if (CALL_STATES < 9 || CALL_STATES > (1 << TW)) begin : g_bad_call
      $error("callseq_core: CALL_STATES out of range for TW");
   end

   logic [TW-1:0] tstate;
   logic [7:0]    opcode;
   uword_t        uw;

   callseq_tstep #(.TW(TW)) u_tstep (
      .clk    (clk),
      .rst_n  (rst_n),
      .last   (uw.last),
      .tstate (tstate)
   );

   callseq_ucode #(.TW(TW), .CALL_STATES(CALL_STATES)) u_ucode (
      .tstate (tstate),
      .opcode (opcode),
      .uw     (uw)
   );

   callseq_dpath #(.AW(AW), .DW(DW)) u_dpath (
      .clk    (clk),
      .rst_n  (rst_n),
      .uw     (uw),
      .rdata  (mem_rdata),
      .addr   (mem_addr),
      .wdata  (mem_wdata),
      .we     (mem_we),
      .opcode (opcode)
   );

   assign fetch_o = (tstate == '0);
endmodule

// File: rtl/callseq_core_chk.sv
module callseq_core_chk #(
   parameter int AW          = 16,
   parameter int DW          = 8,
   parameter int CALL_STATES = 18
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] mem_addr,
   input logic          mem_we,
   input logic          fetch_o
);
   localparam logic [AW-1:0] SAVE_LO = ~AW'(1);
   localparam logic [AW-1:0] SAVE_HI = ~AW'(0);

   logic       started;
   logic [5:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started <= 1'b0;
         gap_q   <= '0;
      end else begin
         started <= 1'b1;
         if (fetch_o)           gap_q <= '0;
         else if (gap_q != '1)  gap_q <= gap_q + 6'd1;
      end
   end

   assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !started |-> (fetch_o && mem_addr == '0 && !mem_we));

   assert_min_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_o && started) |-> (gap_q >= 6'd3));

   assert_max_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_o && started) |-> (int'(gap_q) <= CALL_STATES - 1));

   assert_save_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_addr == SAVE_LO) |=> (mem_we && mem_addr == SAVE_HI));

   assert_save_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_addr == SAVE_HI) |=> !mem_we);

   assert_write_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr == SAVE_LO || mem_addr == SAVE_HI));

   assert_no_write_on_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_o |-> !mem_we);
endmodule

bind callseq_core callseq_core_chk #(
   .AW(AW), .DW(DW), .CALL_STATES(CALL_STATES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_addr (mem_addr),
   .mem_we   (mem_we),
   .fetch_o  (fetch_o)
);

// File: tb/sim_callseq_core.sv
`timescale 1ns/1ps
module sim_callseq_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_we;
   logic [7:0]  mem_rdata;
   logic        fetch_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0]  ram [0:1023];   // upper address bits ignored
   int          wr_n;
   logic [15:0] wr_a [0:3];
   logic [7:0]  wr_d [0:3];

   always #5 clk = ~clk;

   callseq_core u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata),
      .fetch_o   (fetch_o)
   );

   always @(posedge clk) begin
      if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;
      mem_rdata <= ram[mem_addr[9:0]];
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic next_fetch(output int a, output int gap);
      int n = 0;
      wr_n = 0;
      do begin
         @(negedge clk);
         n++;
         if (mem_we) begin
            if (wr_n < 4) begin
               wr_a[wr_n] = mem_addr;
               wr_d[wr_n] = mem_wdata;
            end
            wr_n++;
         end
      end while (!fetch_o && n < 64);
      a   = int'(mem_addr);
      gap = n;
   endtask

   task automatic t_reset();
      for (int i = 0; i < 1024; i++) ram[i] = 8'h00;
      ram[10'h000] = 8'h00;                                        // no-op
      ram[10'h001] = 8'h7F;                                        // undefined
      ram[10'h002] = 8'hC3; ram[10'h003] = 8'h00; ram[10'h004] = 8'h01;
      ram[10'h100] = 8'hCD; ram[10'h101] = 8'h00; ram[10'h102] = 8'h02;
      ram[10'h103] = 8'hCD; ram[10'h104] = 8'hF0; ram[10'h105] = 8'h12;
      ram[10'h106] = 8'hC3; ram[10'h107] = 8'h06; ram[10'h108] = 8'h01;
      ram[10'h200] = 8'h00; ram[10'h201] = 8'hC9;
      ram[10'h2F0] = 8'hC9;                                        // at 12F0h
      repeat (3) @(negedge clk);
      chk(fetch_o == 1'b1, "R1", "fetch in reset", int'(fetch_o), 1);
      chk(mem_we == 1'b0, "R1", "write in reset", int'(mem_we), 0);
      rst_n = 1'b1;
      #1;
      chk(mem_addr == 16'h0000, "R1", "first fetch address", int'(mem_addr), 0);
      chk(fetch_o == 1'b1, "R1", "first cycle is fetch", int'(fetch_o), 1);
   endtask

   task automatic t_plain(input string req, input int exp_a, input int exp_gap);
      int a, g;
      next_fetch(a, g);
      chk(a == exp_a, "R2", {req, " next fetch address"}, a, exp_a);
      chk(g == exp_gap, "R4", {req, " cycle count"}, g, exp_gap);
      chk(wr_n == 0, "R9", {req, " stray writes"}, wr_n, 0);
   endtask

   task automatic t_call(input int target, input int ret);
      int a, g;
      next_fetch(a, g);
      chk(a == target, "R6", "call target fetch", a, target);
      chk(g == 18, "R4", "call cycle count", g, 18);
      chk(wr_n == 2, "R9", "call write count", wr_n, 2);
      chk(wr_a[0] == 16'hFFFE, "R5", "first save address", int'(wr_a[0]), 16'hFFFE);
      chk(int'(wr_d[0]) == (ret & 8'hFF), "R5", "saved low byte", int'(wr_d[0]), ret & 8'hFF);
      chk(wr_a[1] == 16'hFFFF, "R5", "second save address", int'(wr_a[1]), 16'hFFFF);
      chk(int'(wr_d[1]) == (ret >> 8), "R5", "saved high byte", int'(wr_d[1]), ret >> 8);
      chk(int'(ram[10'h3FE]) == (ret & 8'hFF), "R5", "memory low cell", int'(ram[10'h3FE]), ret & 8'hFF);
      chk(int'(ram[10'h3FF]) == (ret >> 8), "R5", "memory high cell", int'(ram[10'h3FF]), ret >> 8);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run hung, actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_plain("R4 no-op", 16'h0001, 4);
      t_plain("R8 undefined opcode", 16'h0002, 4);
      t_plain("R3 jump little-endian", 16'h0100, 7);
      t_call(16'h0200, 16'h0103);
      t_plain("R4 no-op in callee", 16'h0201, 4);
      t_plain("R7 return", 16'h0103, 6);
      t_call(16'h12F0, 16'h0106);
      t_plain("R7 return second", 16'h0106, 6);
      t_plain("R3 jump to self", 16'h0106, 7);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule